// File: doc/BRIEF.md
# Seconds Counter Timer with Alarm

This peripheral keeps a free-running up-count of prescaled ticks of a slow reference clock, typically a 32768 Hz crystal. A 16-bit divisor turns that reference into count steps, so a divisor of 32768 gives one step per second. The count cannot be loaded by software; it can only be returned to zero through a self-clearing control bit. That bit also restarts the divider, so the first step after a clear comes a full divisor period later.

Two sticky event flags are kept. The step flag is raised on every increment. The alarm flag is raised when the count steps onto the value held in the alarm register. The alarm register resets to all ones, and that value disarms the alarm. Reading the status word returns both flags and clears them in the same access. Each flag has an enable bit in the mode word, placed 16 bits above the flag's own position, and the single interrupt line is the OR of the enabled flags.

The slow clock is brought into the bus clock domain by a synchronizer and an edge detector. The count register therefore lives in the bus clock domain, and a bus read can only ever return a complete value.

Top module: `rtt_timer`

## Requirements
- R1: After reset the mode word reads 0x00008000 (divisor 32768, both enables 0), the alarm word reads 0xFFFFFFFF, the count reads 0, the status word reads 0 and `irq` is 0.
- R2: With divisor field D in mode bits 15:0 (D from 1 to 65535), the count at word index 2 rises by exactly one for every D rising edges of `slow_clk`.
- R3: A divisor field of 0 divides by 65536, so fewer than 65536 slow edges produce no increment.
- R4: Writes to the count word (index 2) and the status word (index 3) change nothing. Writing mode with bit 18 set clears the count to 0 and restarts the divider from zero, and bit 18 always reads back as 0.
- R5: Status bit 1 (step flag) is set by every increment of the count.
- R6: Status bit 0 (alarm flag) is set when an increment makes the count equal to the alarm word (index 1). An alarm word of 0xFFFFFFFF never sets it, and a clear through bit 18 never sets it.
- R7: A read of the status word returns the flags as they were before the access and clears both flags.
- R8: If a flag's set event falls in the same cycle as a clearing status read, that flag remains set afterwards.
- R9: `irq` is high exactly while (alarm flag AND mode bit 16) OR (step flag AND mode bit 17) holds. It stays high until a status read clears the enabled flag.
- R10: Consecutive reads of the count while it runs never decrease and never skip a value, so every read returns either the previous count or the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Asynchronous slow reference clock |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 mode, 1 alarm, 2 count, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt request |

## Verification
A divider that loses its phase or ignores the restart shows up in the very next count read, one divisor period after the clear, because the count is off by one step. A sticky flag that is dropped or wrongly raised shows up in the next status read. Through an enabled source, it also shows up on `irq` one cycle after the event or after the clearing read. A clear that wins over a coincident set is caught by a status read placed in exactly the cycle of the increment, and a torn or skipping count is caught by reading back to back while the count runs.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned EN_SHIFT  = 16;
  localparam int unsigned FLAG_ALM  = 0;
  localparam int unsigned FLAG_STEP = 1;
  localparam int unsigned CLR_BIT   = 18;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_ALARM  = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/rtt_edge_sync.sv
module rtt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int unsigned PRES_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              restart,
  input  logic [PRES_W-1:0] divisor,
  output logic              step
);
  localparam int unsigned LIM_W = PRES_W + 1;

  logic [PRES_W-1:0] phase_q;
  logic [LIM_W-1:0]  limit;
  logic [LIM_W-1:0]  phase_inc;

  always_comb begin
    if (divisor == '0) limit = {1'b1, {PRES_W{1'b0}}};
    else               limit = {1'b0, divisor};
    phase_inc = {1'b0, phase_q} + LIM_W'(1);
  end

  assign step = tick & (phase_inc == limit);

  always_ff @(posedge clk) begin
    if (rst || restart)  phase_q <= '0;
    else if (step)       phase_q <= '0;
    else if (tick)       phase_q <= phase_inc[PRES_W-1:0];
  end
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] value,
  output logic             stepped,
  output logic             hit
);
  logic [CNT_W-1:0] value_q;
  logic [CNT_W-1:0] value_inc;
  logic             armed;

  assign value_inc = value_q + CNT_W'(1);
  assign armed     = (alarm != {CNT_W{1'b1}});
  assign stepped   = step & ~clear;
  assign hit       = stepped & armed & (value_inc == alarm);

  always_ff @(posedge clk) begin
    if (rst || clear) value_q <= '0;
    else if (step)    value_q <= value_inc;
  end

  assign value = value_q;
endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
  import rtt_pkg::*;
#(
  parameter int unsigned PRES_W   = 16,
  parameter int unsigned CNT_W    = 32,
  parameter logic [PRES_W-1:0] PRES_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  value,
  input  logic              stepped,
  input  logic              hit,
  output logic [PRES_W-1:0] divisor,
  output logic [CNT_W-1:0]  alarm,
  output logic              clear,
  output logic              alm_flag,
  output logic              step_flag,
  output logic              en_alm,
  output logic              en_step,
  output logic              stat_rd,
  output logic              irq
);
  logic mode_we, alarm_we, rd_en;
  logic alm_nx, step_nx, en_alm_nx, en_step_nx;
  logic [DATA_W-1:0] rd_mux;

  assign mode_we  = bus_sel & bus_wr & (bus_addr == REG_MODE);
  assign alarm_we = bus_sel & bus_wr & (bus_addr == REG_ALARM);
  assign rd_en    = bus_sel & ~bus_wr;
  assign stat_rd  = rd_en & (bus_addr == REG_STATUS);
  assign clear    = mode_we & bus_wdata[CLR_BIT];

  always_comb begin
    en_alm_nx  = mode_we ? bus_wdata[EN_SHIFT + FLAG_ALM]  : en_alm;
    en_step_nx = mode_we ? bus_wdata[EN_SHIFT + FLAG_STEP] : en_step;
    alm_nx     = (alm_flag  & ~stat_rd) | hit;
    step_nx    = (step_flag & ~stat_rd) | stepped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divisor <= PRES_RST;
      en_alm  <= 1'b0;
      en_step <= 1'b0;
    end else if (mode_we) begin
      divisor <= bus_wdata[PRES_W-1:0];
      en_alm  <= en_alm_nx;
      en_step <= en_step_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           alarm <= {CNT_W{1'b1}};
    else if (alarm_we) alarm <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_flag  <= 1'b0;
      step_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      alm_flag  <= alm_nx;
      step_flag <= step_nx;
      irq       <= (alm_nx & en_alm_nx) | (step_nx & en_step_nx);
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      REG_MODE: begin
        rd_mux[PRES_W-1:0]           = divisor;
        rd_mux[EN_SHIFT + FLAG_ALM]  = en_alm;
        rd_mux[EN_SHIFT + FLAG_STEP] = en_step;
      end
      REG_ALARM:  rd_mux[CNT_W-1:0] = alarm;
      REG_COUNT:  rd_mux[CNT_W-1:0] = value;
      REG_STATUS: begin
        rd_mux[FLAG_ALM]  = alm_flag;
        rd_mux[FLAG_STEP] = step_flag;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
  import rtt_pkg::*;
#(
  parameter int unsigned PRES_W    = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned SYNC_STG  = 2,
  parameter logic [PRES_W-1:0] PRES_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              tick, step, stepped, hit, clear;
  logic              alm_flag, step_flag, en_alm, en_step, stat_rd;
  logic [PRES_W-1:0] divisor;
  logic [CNT_W-1:0]  alarm, value;

  rtt_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(slow_clk), .rise(tick)
  );

  rtt_prescaler #(.PRES_W(PRES_W)) u_pres (
    .clk(clk), .rst(rst), .tick(tick), .restart(clear),
    .divisor(divisor), .step(step)
  );

  rtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .clear(clear), .alarm(alarm),
    .value(value), .stepped(stepped), .hit(hit)
  );

  rtt_regs #(.PRES_W(PRES_W), .CNT_W(CNT_W), .PRES_RST(PRES_RST)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .value(value), .stepped(stepped), .hit(hit), .divisor(divisor),
    .alarm(alarm), .clear(clear), .alm_flag(alm_flag),
    .step_flag(step_flag), .en_alm(en_alm), .en_step(en_step),
    .stat_rd(stat_rd), .irq(irq)
  );
endmodule

// File: rtl/rtt_timer_chk.sv
module rtt_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] value,
  input logic [CNT_W-1:0] alarm,
  input logic             step,
  input logic             clear,
  input logic             alm_flag,
  input logic             step_flag,
  input logic             en_alm,
  input logic             en_step,
  input logic             stat_rd,
  input logic             irq
);
  AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (value == $past(value) || value == $past(value) + CNT_W'(1) || value == '0)); // R10

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (value == '0)); // R4

  AST_STEP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> step_flag); // R5

  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (alarm == {CNT_W{1'b1}} && !alm_flag) |=> !alm_flag); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !step) |=> !step_flag); // R7

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((alm_flag && en_alm) || (step_flag && en_step))); // R9
endmodule

bind rtt_timer rtt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .value(value), .alarm(alarm), .step(step),
  .clear(clear), .alm_flag(alm_flag), .step_flag(step_flag),
  .en_alm(en_alm), .en_step(en_step), .stat_rd(stat_rd), .irq(irq)
);

// File: tb/rtt_timer_tb_top.sv
module rtt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CLRB = 32'h0004_0000;
  localparam logic [31:0] EN_A = 32'h0001_0000;
  localparam logic [31:0] EN_S = 32'h0002_0000;

  logic clk = 1'b0, rst = 1'b1, slow_clk = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtt_timer dut_i (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_sel = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_clk = 1;
      repeat (4) @(negedge clk);
      slow_clk = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 mode", d, 32'h0000_8000);
    rd(2'd1, d); check("R1 alarm", d, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R1 count", d, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_divide();
    logic [31:0] d;
    wr(2'd0, CLRB | 3);
    pulses(7); rd(2'd2, d); check("R2 count after 7 edges /3", d, 2);
    pulses(2); rd(2'd2, d); check("R2 count after 9 edges /3", d, 3);
    rd(2'd0, d); check("R4 clear bit reads 0", d, 3);
  endtask

  task automatic t_clear_restart();
    logic [31:0] d;
    wr(2'd0, 3);
    pulses(2);
    wr(2'd2, 32'h1234_5678);
    wr(2'd3, 32'h3);
    rd(2'd2, d); check("R4 count write ignored", d, 3);
    wr(2'd0, CLRB | 3);
    rd(2'd2, d); check("R4 clear zeroes", d, 0);
    pulses(2); rd(2'd2, d); check("R4 divider restarted", d, 0);
    pulses(1); rd(2'd2, d); check("R4 first step after clear", d, 1);
  endtask

  task automatic t_div_zero();
    logic [31:0] d;
    wr(2'd0, CLRB | 0);
    pulses(100); rd(2'd2, d); check("R3 divisor 0 no step", d, 0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    wr(2'd0, CLRB | 1);
    rd(2'd3, d);
    pulses(1);
    rd(2'd3, d); check("R5 step flag", d, 32'h2);
    rd(2'd3, d); check("R7 read cleared", d, 0);
    pulses(2);
    rd(2'd3, d); check("R6 disarmed alarm quiet", d, 32'h2);
  endtask

  task automatic t_alarm_irq();
    logic [31:0] d;
    wr(2'd1, 3);
    wr(2'd0, CLRB | EN_A | 1);
    rd(2'd3, d);
    pulses(2);
    rd(2'd3, d); check("R6 no alarm before match", d, 32'h2);
    check("R9 step not enabled", {31'd0, irq}, 0);
    pulses(1);
    check("R9 irq on alarm", {31'd0, irq}, 1);
    repeat (5) @(negedge clk);
    check("R9 irq held", {31'd0, irq}, 1);
    rd(2'd3, d); check("R6 alarm flag at match", d, 32'h3);
    check("R9 irq drops after read", {31'd0, irq}, 0);
    wr(2'd0, EN_S | 1);
    pulses(1);
    check("R9 irq on step", {31'd0, irq}, 1);
    rd(2'd3, d); check("R6 alarm once only", d, 32'h2);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(2'd0, CLRB | 1);
    repeat (3) @(negedge clk);
    rd(2'd3, d);
    @(negedge clk); slow_clk = 1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 2'd3;
    @(negedge clk);
    d = bus_rdata; bus_sel = 0;
    check("R8 read before event", d, 0);
    repeat (3) @(negedge clk); slow_clk = 0;
    repeat (4) @(negedge clk);
    rd(2'd3, d); check("R8 flag survived clear", d, 32'h2);
  endtask

  task automatic t_coherent();
    logic [31:0] d, prev;
    wr(2'd0, CLRB | 1);
    prev = 0;
    fork
      pulses(10);
      for (int i = 0; i < 40; i++) begin
        rd(2'd2, d);
        if (d != prev && d != prev + 1) check("R10 read coherent", d, prev);
        prev = d;
      end
    join
    repeat (4) @(negedge clk);
    rd(2'd2, d); check("R10 final count", d, 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_divide();
    t_clear_restart();
    t_div_zero();
    t_flags();
    t_alarm_irq();
    t_collide();
    t_coherent();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule